// File: doc/BRIEF.md
# Fault-Tolerant Parity Select Register

This block is a memory-mapped control register. It holds a 4-bit key that picks odd or even parity for the rest of a device. A simple register bus reaches it: address, write enable, write data, a privilege flag, and combinational read data. The block drives a parity-mode output and a key-error flag.

The mode is never stored as a single bit. Odd parity uses the code 4'hA and even parity uses 4'h5, and these two codes are four bits apart. If one bit of the stored key flips, the key stays closest to the code that was last programmed, so that mode stays in force and the block raises an error pulse. If the stored key is two bits away from both codes, the block settles on odd parity, which is the safe choice. A write of a value that is neither code is stored exactly as written, and the same decode rules then set the mode. This lets software, or a test, inject upsets on purpose.

Top module: `parity_sel_reg`

## Requirements
- R1: After reset the stored key is 4'hA, parity_odd is 1 and key_err is 0.
- R2: A write with wr_en=1, priv=1 and addr equal to byte offset 0xDC stores wdata[3:0] as the key. A read at that offset returns the stored key in rdata[3:0] in the same cycle.
- R3: A write with priv=0 leaves the stored key unchanged.
- R4: A write to any address other than 0xDC leaves the key unchanged, and a read at any other address returns all zeros.
- R5: rdata bits 31 to 4 always read as zero, whatever value was written to them.
- R6: Key 4'hA gives parity_odd=1 and key 4'h5 gives parity_odd=0.
- R7: A key that differs from 4'h5 in exactly one bit gives parity_odd=0. A key that differs from 4'hA in exactly one bit gives parity_odd=1.
- R8: A key that differs from both 4'hA and 4'h5 in two bits gives parity_odd=1.
- R9: key_err is 1 for exactly one cycle, in the first cycle in which the stored key is neither 4'hA nor 4'h5. It stays 0 while the key is valid, and it does not pulse again while the key stays invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| priv | input | 1 | Access is privileged |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational on addr |
| parity_odd | output | 1 | 1 selects odd parity, 0 selects even |
| key_err | output | 1 | One-cycle pulse when the key first turns invalid |

## Verification
The bench uses the default parameters: an 8-bit address, a 32-bit data word, the register at offset 0xDC, and the key codes 4'hA and 4'h5. With a 4-bit key, random writes reach all sixteen key values. That covers both valid codes, all eight one-bit upsets and all six two-bit patterns. Random addresses and privilege settings mix hits, misses and unprivileged writes. Back-to-back invalid values test that the error pulse does not repeat.

// File: rtl/parity_sel_reg.sv
module parity_sel_reg #(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          KEY_W      = 4,
  parameter [ADDR_W-1:0] REG_OFFSET = 8'hDC,
  parameter [KEY_W-1:0]  KEY_ODD    = 4'hA,
  parameter [KEY_W-1:0]  KEY_EVEN   = 4'h5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              priv,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              parity_odd,
  output logic              key_err
);

  localparam int PAD_W = DATA_W - KEY_W;

  logic [KEY_W-1:0] key;
  logic             bad_q;
  logic             hit;
  logic             bad;
  int               dist_even;
  logic             unused_wdata;

  assign hit          = (addr == REG_OFFSET);
  assign unused_wdata = ^wdata[DATA_W-1:KEY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key   <= KEY_ODD;
      bad_q <= 1'b0;
    end else begin
      if (wr_en && priv && hit)
        key <= wdata[KEY_W-1:0];
      bad_q <= bad;
    end
  end

  assign bad        = (key != KEY_ODD) && (key != KEY_EVEN);
  assign dist_even  = $countones(key ^ KEY_EVEN);
  assign parity_odd = !(dist_even <= 1);
  assign key_err    = bad && !bad_q;
  assign rdata      = hit ? {{PAD_W{1'b0}}, key} : '0;

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && priv && hit) |=> (rdata[KEY_W-1:0] == $past(wdata[KEY_W-1:0]) || !hit)); // R2
  AST_NONPRIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv) |=> $stable(key)); // R3
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(key)); // R4
  AST_EVEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[KEY_W-1:0] == KEY_EVEN && hit) |-> !parity_odd); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_err |=> !key_err); // R9
  AST_VALID_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
    !bad |-> !key_err); // R9

endmodule

// File: tb/test_parity_sel_reg.sv
module test_parity_sel_reg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 0;
  logic        wr_en = 0;
  logic        priv = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        parity_odd;
  logic        key_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [3:0] mkey;
  bit         mbad_prev;

  always #2 clk = ~clk;

  parity_sel_reg i_parity_sel_reg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .priv(priv),
    .wdata(wdata), .rdata(rdata), .parity_odd(parity_odd), .key_err(key_err));

  function automatic bit is_bad(input logic [3:0] k);
    return (k != 4'hA) && (k != 4'h5);
  endfunction

  function automatic logic exp_odd(input logic [3:0] k);
    return !($countones(k ^ 4'h5) <= 1);
  endfunction

  function automatic string mode_tag(input logic [3:0] k);
    if (!is_bad(k)) return "R6";
    if ($countones(k ^ 4'h5) == 1 || $countones(k ^ 4'hA) == 1) return "R7";
    return "R8";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] a, input bit we, input bit pv, input logic [31:0] wd);
    addr = a; wr_en = we; priv = pv; wdata = wd;
    #1;
    chk(a == 8'hDC ? "R2" : "R4", rdata, a == 8'hDC ? {28'h0, mkey} : 32'h0);
    chk("R5", {4'h0, rdata[31:4]}, 32'h0);
    @(posedge clk);
    mbad_prev = is_bad(mkey);
    if (we && pv && a == 8'hDC) mkey = wd[3:0];
    @(negedge clk);
    wr_en = 0;
    chk(mode_tag(mkey), {31'h0, parity_odd}, {31'h0, exp_odd(mkey)});
    chk("R9", {31'h0, key_err}, {31'h0, is_bad(mkey) && !mbad_prev});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    mkey = 4'hA; mbad_prev = 0;
    #9 rst_n = 1;
    @(negedge clk);
    chk("R1", {28'h0, i_parity_sel_reg.rdata[3:0]} & 32'h0, 32'h0);
    addr = 8'hDC; #1;
    chk("R1", rdata, 32'hA);
    chk("R1", {30'h0, parity_odd, key_err}, 32'h2);
    @(negedge clk);
    op(8'hDC, 1, 0, 32'h5);
    op(8'hDC, 0, 0, 0);
    chk("R3", rdata, 32'hA);
    op(8'hD8, 1, 1, 32'h5);
    op(8'hDC, 0, 0, 0);
    chk("R4", rdata, 32'hA);
    op(8'hDC, 1, 1, 32'hFFFF_FFF5);
    op(8'hDC, 1, 1, 32'h4);
    op(8'hDC, 1, 1, 32'h6);
    op(8'hDC, 1, 1, 32'h0);
    op(8'hDC, 1, 1, 32'hA);
    op(8'hDC, 1, 1, 32'hB);
    op(8'hDC, 1, 1, 32'h3);
    op(8'hDC, 1, 1, 32'h5);
    for (int v = 0; v < 16; v++) begin
      op(8'hDC, 1, 1, {28'h0, 4'(v)});
      op(8'hDC, 1, 1, 32'hA);
    end
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = ($urandom % 2) ? 8'hDC : 8'($urandom);
      op(a, 1'($urandom), 1'($urandom), $urandom);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule